// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the eight already-synchronized input pins of a general-purpose I/O port and raises one port-level interrupt. Software picks a detection style for each pin on its own. A pin can be edge-sensitive, on one edge or on both edges, or it can be level-sensitive. The active polarity is also per pin: a rising edge or a high level, or a falling edge or a low level.

In edge mode a detected edge sets a sticky status bit. The bit stays set until software writes a one to the matching bit of the clear register. In level mode the status bit simply follows the pin. A per-pin enable mask turns the raw status into masked status, and the single interrupt output is the OR of all masked bits. All of this is reached through seven registers on a simple single-cycle register bus.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. The stored previous pin sample resets to 0, so a pin that is high when reset is released counts as a rising edge.
- R2: Register offsets on `bus_addr` are:
  - 0: sense select (1 = level, 0 = edge)
  - 1: dual-edge select
  - 2: polarity
  - 3: enable mask
  - 4: raw status
  - 5: masked status
  - 6: clear

  Offsets 0 to 3 read back what was written. Writes to offsets 4 and 5 change nothing. Offset 6 reads 0, and so does any other offset.
- R3: For a pin in edge mode with dual-edge off, polarity 1 detects a rising edge and polarity 0 detects a falling edge. An edge is a difference between the pin sampled at a clock edge and its sample at the previous clock edge. The raw bit is set from the cycle after that clock edge.
- R4: For a pin in edge mode with dual-edge set, a rising edge and a falling edge both set the raw bit, whatever the polarity bit is.
- R5: A latched edge bit stays set until a bus write to offset 6 carries a 1 in that bit position. The bit then reads 0 from the next cycle. Clear bits that are written as 0 leave their status bits unchanged.
- R6: If an edge is detected on the same clock edge as a clear of that bit, the bit ends up set.
- R7: For a pin in level mode, the raw bit equals the pin when polarity is 1, and the inverted pin when polarity is 0, in the same cycle. The dual-edge bit has no effect on such a pin, and its edge latch is emptied while level mode is selected.
- R8: Masked status equals raw status AND the enable mask. `irq_o` is high exactly when any masked bit is 1.
- R9: A raw status bit shows the detected condition whether or not its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_i | input | 8 | Synchronized pin levels |
| irq_o | output | 1 | Port interrupt, OR of masked status |

## Verification
The hardest situation to reach is a new edge on a pin on the very clock edge where software clears that same pin's latched bit. The clear must lose in that case. The random stimulus reaches it by putting clear writes in the same cycle as pin toggles, and a directed case forces it on a known pin. A second hard case is a mode switch while a bit is latched, which must empty the latch. The random phase reaches it by rewriting the sense, dual-edge and polarity registers at random points while the pins keep toggling.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] OFF_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DUAL  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_POL   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_MSKD  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 3'd6;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   sense_o,
    output logic [PINS-1:0]   dual_o,
    output logic [PINS-1:0]   pol_o,
    output logic [PINS-1:0]   mask_o,
    output logic [PINS-1:0]   clr_o
);
    typedef struct packed {
        logic [PINS-1:0] sense;
        logic [PINS-1:0] dual;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [PINS-1:0] clr_d;

    always_comb begin
        cfg_d = cfg_q;
        clr_d = '0;
        if (wr_en) begin
            case (addr)
                OFF_SENSE: cfg_d.sense = wdata;
                OFF_DUAL:  cfg_d.dual  = wdata;
                OFF_POL:   cfg_d.pol   = wdata;
                OFF_MASK:  cfg_d.mask  = wdata;
                OFF_CLR:   clr_d       = wdata;
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sense_o = cfg_q.sense;
    assign dual_o  = cfg_q.dual;
    assign pol_o   = cfg_q.pol;
    assign mask_o  = cfg_q.mask;
    assign clr_o   = clr_d;

    // R5: a clear pulse only exists during a bus write
    p_clr_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> wr_en);

    // R2: writes to the status offsets leave the configuration alone
    p_status_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFF_RAW || addr == OFF_MSKD)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sense_i,
    input  logic dual_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic raw_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic rise, fall, hit, level_act;

    always_comb begin
        rise      = pin_i & ~st_q.prev;
        fall      = ~pin_i & st_q.prev;
        hit       = dual_i ? (rise | fall) : (pol_i ? rise : fall);
        level_act = pol_i ? pin_i : ~pin_i;
        st_d.prev = pin_i;
        if (sense_i) st_d.latch = 1'b0;
        else         st_d.latch = hit | (st_q.latch & ~clr_i);
        raw_o = sense_i ? level_act : st_q.latch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: latched edge survives while not cleared
    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && st_q.latch && !clr_i) |=> st_q.latch);

    // R5: a clear with no new edge empties the latch
    p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && clr_i && (pin_i == st_q.prev)) |=> !st_q.latch);

    // R4 / R6: any pin change in dual-edge mode latches, even against a clear
    p_dual_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && dual_i && (pin_i != st_q.prev)) |=> st_q.latch);

    // R7: level mode leaves the edge latch empty
    p_level_drops_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i |=> !st_q.latch);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_i,
    output logic              irq_o
);
    logic [PINS-1:0] sense, dual, pol, mask, clr, raw, masked;

    gpio_irq_cfg #(.PINS(PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .sense_o (sense),
        .dual_o  (dual),
        .pol_o   (pol),
        .mask_o  (mask),
        .clr_o   (clr)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[g]),
            .sense_i (sense[g]),
            .dual_i  (dual[g]),
            .pol_i   (pol[g]),
            .clr_i   (clr[g]),
            .raw_o   (raw[g])
        );
    end

    always_comb begin
        masked = raw & mask;
        irq_o  = |masked;
        case (bus_addr)
            OFF_SENSE: bus_rdata = sense;
            OFF_DUAL:  bus_rdata = dual;
            OFF_POL:   bus_rdata = pol;
            OFF_MASK:  bus_rdata = mask;
            OFF_RAW:   bus_rdata = raw;
            OFF_MSKD:  bus_rdata = masked;
            default:   bus_rdata = '0;
        endcase
    end

    // R8: with every pin disabled, no interrupt
    p_no_irq_when_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R9: an enabled, raised status bit always drives the interrupt
    p_irq_from_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) != '0) |-> irq_o);
endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_i = 8'd0;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state derived from the requirements
    logic [7:0] m_sense = 0, m_dual = 0, m_pol = 0, m_mask = 0;
    logic [7:0] m_prev = 0, m_latch = 0;

    always #4 clk = ~clk;

    gpio_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_raw(input logic [7:0] p);
        logic [7:0] lvl;
        lvl = ~(p ^ m_pol);
        return (m_sense & lvl) | (~m_sense & m_latch);
    endfunction

    function automatic logic [7:0] exp_hit(input logic [7:0] p);
        logic [7:0] r, f;
        r = p & ~m_prev;
        f = ~p & m_prev;
        return (m_dual & (r | f)) | (~m_dual & ((m_pol & r) | (~m_pol & f)));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sense = 0; m_dual = 0; m_pol = 0; m_mask = 0; m_prev = 0; m_latch = 0;
        end else begin
            logic [7:0] clr;
            clr = (bus_wr && bus_addr == 3'd6) ? bus_wdata : 8'd0;
            m_latch = ~m_sense & (exp_hit(pin_i) | (m_latch & ~clr));
            m_prev = pin_i;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_sense = bus_wdata;
                    3'd1: m_dual  = bus_wdata;
                    3'd2: m_pol   = bus_wdata;
                    3'd3: m_mask  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [7:0] expv, input string tag);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, expv);
    endtask

    // Drive pins at the falling edge, check status, then set up the bus for the next rising edge
    task automatic tick(input logic [7:0] p, input logic w, input logic [2:0] a,
                        input logic [7:0] d, input string tag);
        logic [7:0] r;
        @(negedge clk);
        pin_i = p;
        r = exp_raw(p);
        read_chk(3'd4, r, {tag, " raw"});
        read_chk(3'd5, r & m_mask, {"R8 masked ", tag});
        check({"R8 irq ", tag}, {7'd0, irq_o}, {7'd0, |(r & m_mask)});
        bus_wr = w;
        bus_addr = a;
        bus_wdata = d;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 7; a++) read_chk(3'(a), 8'h00, "R1 reset register");
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);

        // R2: register readback and ignored writes
        tick(8'h00, 1'b1, 3'd1, 8'h3C, "R2");
        tick(8'h00, 1'b1, 3'd3, 8'hC3, "R2");
        tick(8'h00, 1'b1, 3'd4, 8'hFF, "R2");
        tick(8'h00, 1'b1, 3'd5, 8'hFF, "R2");
        @(negedge clk);
        read_chk(3'd1, 8'h3C, "R2 dual readback");
        read_chk(3'd3, 8'hC3, "R2 mask readback");
        read_chk(3'd4, 8'h00, "R2 raw unchanged by write");
        read_chk(3'd6, 8'h00, "R2 clear reads zero");
        read_chk(3'd7, 8'h00, "R2 unused offset");

        // R3: rising edges, positive polarity
        tick(8'h00, 1'b1, 3'd1, 8'h00, "R3");
        tick(8'h00, 1'b1, 3'd2, 8'hFF, "R3");
        tick(8'h00, 1'b1, 3'd3, 8'hFF, "R3");
        tick(8'h01, 1'b0, 3'd0, 8'h00, "R3");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R3");
        read_chk(3'd4, 8'h01, "R3 rising edge latched");
        // R5: write 0 has no effect, write 1 clears
        tick(8'h00, 1'b1, 3'd6, 8'hFE, "R5");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R5");
        read_chk(3'd4, 8'h01, "R5 zero clear bits keep latch");
        tick(8'h00, 1'b1, 3'd6, 8'h01, "R5");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R5");
        read_chk(3'd4, 8'h00, "R5 clear empties latch");

        // R6: edge and clear on the same clock edge
        tick(8'h02, 1'b1, 3'd6, 8'h02, "R6");
        tick(8'h02, 1'b0, 3'd0, 8'h00, "R6");
        read_chk(3'd4, 8'h02, "R6 set wins over clear");
        tick(8'h02, 1'b1, 3'd6, 8'h02, "R6");

        // R3: falling edge with polarity 0
        tick(8'h02, 1'b1, 3'd2, 8'h00, "R3");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R3");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R3");
        read_chk(3'd4, 8'h02, "R3 falling edge latched");
        tick(8'h00, 1'b1, 3'd6, 8'hFF, "R5");

        // R4: both edges regardless of polarity
        tick(8'h00, 1'b1, 3'd1, 8'hFF, "R4");
        tick(8'h10, 1'b0, 3'd0, 8'h00, "R4");
        tick(8'h10, 1'b1, 3'd6, 8'hFF, "R4");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R4");
        tick(8'h00, 1'b0, 3'd0, 8'h00, "R4");
        read_chk(3'd4, 8'h10, "R4 falling edge in dual mode");

        // R7: level mode, mixed polarity
        tick(8'h00, 1'b1, 3'd2, 8'h0F, "R7");
        tick(8'h00, 1'b1, 3'd0, 8'hFF, "R7");
        tick(8'h05, 1'b0, 3'd0, 8'h00, "R7");
        read_chk(3'd4, 8'hF5, "R7 level follows pins");

        // R8 / R9: masked off, raw still visible
        tick(8'h05, 1'b1, 3'd3, 8'h00, "R9");
        tick(8'h05, 1'b0, 3'd0, 8'h00, "R9");
        read_chk(3'd4, 8'hF5, "R9 raw ignores mask");
        read_chk(3'd5, 8'h00, "R8 masked off");
        check("R8 irq low when masked", {7'd0, irq_o}, 8'h00);

        // Random phase across R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] p;
            int sel;
            p = 8'($urandom);
            sel = int'($urandom % 16);
            if (sel < 2)       tick(p, 1'b1, 3'($urandom % 4), 8'($urandom), "R3 R4 R7 random");
            else if (sel < 6)  tick(p, 1'b1, 3'd6, 8'($urandom), "R5 R6 random");
            else if (sel == 6) tick(p, 1'b1, 3'(4 + $urandom % 2), 8'($urandom), "R2 random");
            else               tick(p, 1'b0, 3'd0, 8'h00, "R3 R4 R7 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule